// File: doc/BRIEF.md
# Local-Bus GPIO Register Block

This block is a register slave on a processor's external local bus. The bus has a 32-bit data path, nine word-address lines, an active-low chip select and separate active-low read and write strobes. All of these are sampled on a single bus clock, nominally 125 MHz. The nine address lines index 512 words. Only five of those words are populated: a fixed identification word, and a data register plus a direction register for each of two general-purpose ports. One port is 24 bits wide and the other is 12 bits wide.

Every pin on both ports can be set as an input or an output on its own. Each pad is modelled as an output value together with an output-enable bit. Software tells a build apart by reading the identification word. It then sets the direction bits, writes output values and reads back pin states. Pin inputs pass through a two-stage synchronizer before they can be read.

Top module: `lbgpio_top`

## Requirements
- R1: Word index 0 (byte offset 0x00) reads as the constant 0x4C810001, and a write to it changes no output.
- R2: Word index 8 (byte 0x20) is the 24-bit output latch of port A. A write commits bits 23:0 and shows them on `pa_out` at the next rising edge. Bits 31:24 of the write are ignored.
- R3: Word index 9 (byte 0x24) is the port A direction register. A 1 in a bit makes that pin an output. `pa_oe` shows the value at the next rising edge, and a read returns it with bits 31:24 as zero.
- R4: Word indices 10 and 11 (bytes 0x28 and 0x2C) are the 12-bit data and direction registers of port B. `pb_out` and `pb_oe` follow them. Reads of either register return bits 31:12 as zero.
- R5: A read of a port data register returns, per bit, the output latch where the direction bit is 1 and the synchronized pin where it is 0. A pin change becomes visible to a read after the second rising edge that follows it.
- R6: `bus_rdata_oe` is high exactly while `bus_cs_n` and `bus_rd_n` are both low. `bus_rdata` is zero whenever `bus_rdata_oe` is low.
- R7: A write commits on the first rising edge at which `bus_cs_n` and `bus_wr_n` are both low. Later edges of the same continuous assertion do not commit again, even if the data changes.
- R8: Word indices other than 0, 8, 9, 10 and 11 read as zero and ignore writes.
- R9: Reset (`rst` high) clears every direction bit and every output latch, so `pa_oe`, `pb_oe`, `pa_out` and `pb_out` are all zero.
- R10: With `bus_cs_n` high, a low write or read strobe changes no register and does not drive the data bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_cs_n | input | 1 | Chip select, active low |
| bus_rd_n | input | 1 | Read strobe, active low |
| bus_wr_n | input | 1 | Write strobe, active low |
| bus_addr | input | 9 | Word address (byte address bits 10:2) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, zero when not driven |
| bus_rdata_oe | output | 1 | Data bus drive enable |
| pa_in | input | 24 | Port A pin inputs |
| pa_out | output | 24 | Port A pin output values |
| pa_oe | output | 24 | Port A pin output enables |
| pb_in | input | 12 | Port B pin inputs |
| pb_out | output | 12 | Port B pin output values |
| pb_oe | output | 12 | Port B pin output enables |

## Verification
The register walk writes patterns whose bits fall outside the port width (0xFF in the top byte, 0xFFFF into a 12-bit register). This shows whether the upper bits are truly dropped or leak into the readback. A mixed direction mask of 0xF0F0F0, combined with a latch of 0xAAAAAA and pins held at 0x555555, gives a readback of 0xA5A5A5. That single value shows which source each bit was taken from. A pin step is read one edge and two edges after it happens, which separates a correct two-stage synchronizer from a shorter or longer one. A write strobe held low while the data changes, and strobes given with chip select high, show whether a commit happens once per assertion and only while the block is selected.

// File: rtl/lbgpio_pkg.sv
package lbgpio_pkg;
  localparam int ADDR_W = 9;
  localparam int DATA_W = 32;
  localparam int PA_W   = 24;
  localparam int PB_W   = 12;
  localparam logic [DATA_W-1:0] ID_WORD = 32'h4C81_0001;
  // word indices (byte offset / 4)
  localparam logic [ADDR_W-1:0] IDX_ID     = 9'd0;
  localparam logic [ADDR_W-1:0] IDX_PA_DAT = 9'd8;
  localparam logic [ADDR_W-1:0] IDX_PA_DIR = 9'd9;
  localparam logic [ADDR_W-1:0] IDX_PB_DAT = 9'd10;
  localparam logic [ADDR_W-1:0] IDX_PB_DIR = 9'd11;
endpackage

// File: rtl/lbgpio_sync.sv
module lbgpio_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stage_q[0] <= '0;
    else     stage_q[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stage_q[s] <= '0;
      else     stage_q[s] <= stage_q[s-1];
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/lbgpio_port.sv
module lbgpio_port #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we_dat,
  input  logic         we_dir,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] pin_in,
  output logic [W-1:0] pin_out,
  output logic [W-1:0] pin_oe,
  output logic [W-1:0] dat_rd,
  output logic [W-1:0] dir_rd
);
  logic [W-1:0] latch_q;
  logic [W-1:0] dir_q;
  logic [W-1:0] pin_sync;

  lbgpio_sync #(.W(W), .STAGES(2)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (pin_in),
    .q   (pin_sync)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      latch_q <= '0;
      dir_q   <= '0;
    end else begin
      if (we_dat) latch_q <= wdata;
      if (we_dir) dir_q   <= wdata;
    end
  end

  assign pin_out = latch_q;
  assign pin_oe  = dir_q;
  assign dat_rd  = (latch_q & dir_q) | (pin_sync & ~dir_q);
  assign dir_rd  = dir_q;
endmodule

// File: rtl/lbgpio_bus_dec.sv
module lbgpio_bus_dec
  import lbgpio_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic [ADDR_W-1:0] addr,
  output logic              rd_act,
  output logic              we_pa_dat,
  output logic              we_pa_dir,
  output logic              we_pb_dat,
  output logic              we_pb_dir
);
  logic wr_act;
  logic wr_act_q;
  logic wr_start;

  assign wr_act   = !cs_n && !wr_n;
  assign rd_act   = !cs_n && !rd_n;
  assign wr_start = wr_act && !wr_act_q;

  always_ff @(posedge clk) begin
    if (rst) wr_act_q <= 1'b0;
    else     wr_act_q <= wr_act;
  end

  assign we_pa_dat = wr_start && (addr == IDX_PA_DAT);
  assign we_pa_dir = wr_start && (addr == IDX_PA_DIR);
  assign we_pb_dat = wr_start && (addr == IDX_PB_DAT);
  assign we_pb_dir = wr_start && (addr == IDX_PB_DIR);
endmodule

// File: rtl/lbgpio_top.sv
module lbgpio_top
  import lbgpio_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_cs_n,
  input  logic              bus_rd_n,
  input  logic              bus_wr_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_rdata_oe,
  input  logic [PA_W-1:0]   pa_in,
  output logic [PA_W-1:0]   pa_out,
  output logic [PA_W-1:0]   pa_oe,
  input  logic [PB_W-1:0]   pb_in,
  output logic [PB_W-1:0]   pb_out,
  output logic [PB_W-1:0]   pb_oe
);
  logic rd_act, we_pa_dat, we_pa_dir, we_pb_dat, we_pb_dir;
  logic [PA_W-1:0] pa_dat_rd, pa_dir_rd;
  logic [PB_W-1:0] pb_dat_rd, pb_dir_rd;
  logic [DATA_W-1:0] rd_mux;
  logic unused_wdata_hi;

  assign unused_wdata_hi = ^bus_wdata[DATA_W-1:PA_W];

  lbgpio_bus_dec u_dec (
    .clk       (clk),
    .rst       (rst),
    .cs_n      (bus_cs_n),
    .rd_n      (bus_rd_n),
    .wr_n      (bus_wr_n),
    .addr      (bus_addr),
    .rd_act    (rd_act),
    .we_pa_dat (we_pa_dat),
    .we_pa_dir (we_pa_dir),
    .we_pb_dat (we_pb_dat),
    .we_pb_dir (we_pb_dir)
  );

  lbgpio_port #(.W(PA_W)) u_port_a (
    .clk     (clk),
    .rst     (rst),
    .we_dat  (we_pa_dat),
    .we_dir  (we_pa_dir),
    .wdata   (bus_wdata[PA_W-1:0]),
    .pin_in  (pa_in),
    .pin_out (pa_out),
    .pin_oe  (pa_oe),
    .dat_rd  (pa_dat_rd),
    .dir_rd  (pa_dir_rd)
  );

  lbgpio_port #(.W(PB_W)) u_port_b (
    .clk     (clk),
    .rst     (rst),
    .we_dat  (we_pb_dat),
    .we_dir  (we_pb_dir),
    .wdata   (bus_wdata[PB_W-1:0]),
    .pin_in  (pb_in),
    .pin_out (pb_out),
    .pin_oe  (pb_oe),
    .dat_rd  (pb_dat_rd),
    .dir_rd  (pb_dir_rd)
  );

  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      IDX_ID:     rd_mux = ID_WORD;
      IDX_PA_DAT: rd_mux[PA_W-1:0] = pa_dat_rd;
      IDX_PA_DIR: rd_mux[PA_W-1:0] = pa_dir_rd;
      IDX_PB_DAT: rd_mux[PB_W-1:0] = pb_dat_rd;
      IDX_PB_DIR: rd_mux[PB_W-1:0] = pb_dir_rd;
      default:    rd_mux = '0;
    endcase
  end

  assign bus_rdata_oe = rd_act;
  assign bus_rdata    = rd_act ? rd_mux : '0;
endmodule

// File: rtl/lbgpio_chk.sv
module lbgpio_chk
  import lbgpio_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              bus_cs_n,
  input logic              bus_rd_n,
  input logic              bus_wr_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              bus_rdata_oe,
  input logic [PA_W-1:0]   pa_out,
  input logic [PA_W-1:0]   pa_oe,
  input logic [PB_W-1:0]   pb_out,
  input logic [PB_W-1:0]   pb_oe
);
  logic wr_seen_q;
  logic first_wr;

  always_ff @(posedge clk) begin
    if (rst) wr_seen_q <= 1'b0;
    else     wr_seen_q <= !bus_cs_n && !bus_wr_n;
  end
  assign first_wr = !bus_cs_n && !bus_wr_n && !wr_seen_q;

  // R6
  idle_bus_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !bus_rdata_oe |-> (bus_rdata == '0));

  // R9
  reset_clears_chk: assert property (@(posedge clk)
    rst |=> (pa_oe == '0 && pb_oe == '0 && pa_out == '0 && pb_out == '0));

  // R7
  no_commit_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !first_wr |=> ($stable(pa_out) && $stable(pa_oe) && $stable(pb_out) && $stable(pb_oe)));

  // R1
  id_write_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (first_wr && bus_addr == IDX_ID) |=> ($stable(pa_out) && $stable(pa_oe) && $stable(pb_out) && $stable(pb_oe)));

  // R3
  pa_dir_commit_chk: assert property (@(posedge clk) disable iff (rst)
    (first_wr && bus_addr == IDX_PA_DIR) |=> (pa_oe == $past(bus_wdata[PA_W-1:0])));

  // R4
  pb_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (!bus_cs_n && !bus_rd_n && (bus_addr == IDX_PB_DAT || bus_addr == IDX_PB_DIR)) |-> (bus_rdata[DATA_W-1:PB_W] == '0));
endmodule

bind lbgpio_top lbgpio_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .bus_cs_n     (bus_cs_n),
  .bus_rd_n     (bus_rd_n),
  .bus_wr_n     (bus_wr_n),
  .bus_addr     (bus_addr),
  .bus_wdata    (bus_wdata),
  .bus_rdata    (bus_rdata),
  .bus_rdata_oe (bus_rdata_oe),
  .pa_out       (pa_out),
  .pa_oe        (pa_oe),
  .pb_out       (pb_out),
  .pb_oe        (pb_oe)
);

// File: tb/lbgpio_top_tb.sv
module lbgpio_top_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_cs_n = 1'b1, bus_rd_n = 1'b1, bus_wr_n = 1'b1;
  logic [8:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rdata_oe;
  logic [23:0] pa_in = 24'h555555;
  logic [23:0] pa_out, pa_oe;
  logic [11:0] pb_in = '0;
  logic [11:0] pb_out, pb_oe;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  lbgpio_top u_dut (
    .clk(clk), .rst(rst), .bus_cs_n(bus_cs_n), .bus_rd_n(bus_rd_n),
    .bus_wr_n(bus_wr_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_rdata_oe(bus_rdata_oe),
    .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
    .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe)
  );

  typedef struct packed {
    logic        wr;
    logic [8:0]  addr;
    logic [31:0] data;
    logic [31:0] exp;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 9'd0,   32'h0,        32'h4C810001}, // R1 id read
    '{1'b1, 9'd0,   32'hFFFFFFFF, 32'h0},        // R1 write to id
    '{1'b0, 9'd0,   32'h0,        32'h4C810001}, // R1 id unchanged
    '{1'b1, 9'd9,   32'hFFFFFFFF, 32'h0},        // R3 all outputs
    '{1'b0, 9'd9,   32'h0,        32'h00FFFFFF}, // R3 readback
    '{1'b1, 9'd8,   32'hFFAAAAAA, 32'h0},        // R2 latch
    '{1'b0, 9'd8,   32'h0,        32'h00AAAAAA}, // R2 readback
    '{1'b1, 9'd11,  32'h0000FFFF, 32'h0},        // R4 pb dir
    '{1'b0, 9'd11,  32'h0,        32'h00000FFF}, // R4 upper zero
    '{1'b1, 9'd10,  32'h00000ABC, 32'h0},        // R4 pb data
    '{1'b0, 9'd10,  32'h0,        32'h00000ABC}, // R4 readback
    '{1'b1, 9'd5,   32'h12345678, 32'h0},        // R8 unmapped write
    '{1'b0, 9'd5,   32'h0,        32'h0},        // R8 unmapped read
    '{1'b0, 9'h1FF, 32'h0,        32'h0},        // R8 top word
    '{1'b1, 9'd9,   32'h00F0F0F0, 32'h0},        // R5 mixed dir
    '{1'b0, 9'd9,   32'h0,        32'h00F0F0F0}, // R3 readback
    '{1'b0, 9'd8,   32'h0,        32'h00A5A5A5}  // R5 mixed source
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [8:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_cs_n = 1'b0; bus_wr_n = 1'b0;
    @(negedge clk);
    bus_cs_n = 1'b1; bus_wr_n = 1'b1;
  endtask

  task automatic bus_read(input logic [8:0] a, output logic [31:0] d, output logic oe);
    @(negedge clk);
    bus_addr = a; bus_cs_n = 1'b0; bus_rd_n = 1'b0;
    #1;
    d = bus_rdata; oe = bus_rdata_oe;
    @(negedge clk);
    bus_cs_n = 1'b1; bus_rd_n = 1'b1;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] rd;
    logic oe;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R9 reset state
    check("R9 pa_oe", {8'h0, pa_oe}, 32'h0);
    check("R9 pb_oe", {20'h0, pb_oe}, 32'h0);
    check("R9 pa_out", {8'h0, pa_out}, 32'h0);
    rst = 1'b0;
    @(negedge clk);
    check("R6 idle oe", {31'h0, bus_rdata_oe}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      if (VECS[i].wr) bus_write(VECS[i].addr, VECS[i].data);
      else begin
        bus_read(VECS[i].addr, rd, oe);
        check($sformatf("R1-table vec%0d", i), rd, VECS[i].exp);
        check("R6 oe during read", {31'h0, oe}, 32'h1);
      end
    end
    // R2 R3 R4 pins
    check("R2 pa_out", {8'h0, pa_out}, 32'h00AAAAAA);
    check("R3 pa_oe", {8'h0, pa_oe}, 32'h00F0F0F0);
    check("R4 pb_out", {20'h0, pb_out}, 32'h00000ABC);
    check("R4 pb_oe", {20'h0, pb_oe}, 32'h00000FFF);

    // R5 synchronizer latency: all port A as inputs
    bus_write(9'd9, 32'h0);
    @(negedge clk); pa_in = 24'h123456;
    @(negedge clk); // one rising edge since change
    bus_addr = 9'd8; bus_cs_n = 1'b0; bus_rd_n = 1'b0; #1;
    check("R5 after one edge", bus_rdata, 32'h00555555);
    @(negedge clk); #1; // second edge passed
    check("R5 after two edges", bus_rdata, 32'h00123456);
    bus_cs_n = 1'b1; bus_rd_n = 1'b1;

    // R6 cs low, rd high: no drive
    @(negedge clk);
    bus_addr = 9'd0; bus_cs_n = 1'b0; #1;
    check("R6 cs only oe", {31'h0, bus_rdata_oe}, 32'h0);
    check("R6 cs only data", bus_rdata, 32'h0);
    bus_cs_n = 1'b1;

    // R7 held strobe commits once
    @(negedge clk);
    bus_addr = 9'd8; bus_wdata = 32'h111111; bus_cs_n = 1'b0; bus_wr_n = 1'b0;
    @(negedge clk);
    bus_wdata = 32'h222222;
    @(negedge clk);
    check("R7 held strobe", {8'h0, pa_out}, 32'h00111111);
    bus_cs_n = 1'b1; bus_wr_n = 1'b1;
    bus_write(9'd8, 32'h222222);
    @(negedge clk);
    check("R7 new strobe", {8'h0, pa_out}, 32'h00222222);

    // R10 strobes without chip select
    @(negedge clk);
    bus_addr = 9'd8; bus_wdata = 32'h333333; bus_wr_n = 1'b0; bus_rd_n = 1'b0;
    @(negedge clk); @(negedge clk);
    check("R10 no cs write", {8'h0, pa_out}, 32'h00222222);
    check("R10 no cs drive", {31'h0, bus_rdata_oe}, 32'h0);
    bus_wr_n = 1'b1; bus_rd_n = 1'b1;

    // R9 reset mid-run
    bus_write(9'd9, 32'h00FFFFFF);
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    check("R9 mid-run pa_oe", {8'h0, pa_oe}, 32'h0);
    check("R9 mid-run pb_oe", {20'h0, pb_oe}, 32'h0);
    check("R9 mid-run pb_out", {20'h0, pb_out}, 32'h0);
    rst = 1'b0;

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule